// File: doc/BRIEF.md
# PPS Synchronizer and Stop-Edge Gate

This block takes an asynchronous one-pulse-per-second input into the reference clock domain. The reference clock is normally 10 MHz, and the same clock times the external fine interpolator. A flop chain resynchronizes the pulse. Its rising edge becomes a one-cycle start event. A free-running coarse counter is sampled on that event to give the start timestamp.

After the start event the block opens a gated window of stop events on later reference edges. A programmable mask blanks the first few edges, so that no stop lands inside the interpolator's dead time just after start. When the mask expires, a burst of one to five stop events is passed on consecutive reference edges, exactly one period apart. Each stop carries a report on a valid-only stream:

- the coarse count of that edge;
- its index within the burst.

The report stream has no ready input. A stop edge is fixed in time by the reference clock and cannot be held back. A consumer must therefore accept one report per cycle for the length of the burst.

The mask length and the burst length are read only when a start event is accepted. Pulses that arrive while a measurement is in progress are counted as overruns and do not disturb it. A done flag marks the end of each measurement.

Top module: `pps_stop_gate`

## Requirements
- R1: `start_pulse` is high for exactly one cycle for each rising edge of `pps_async`, whatever the width of the input pulse. With SYNC_STAGES = 2, it is high in the second cycle after the first clock edge that samples `pps_async` high.
- R2: The coarse counter increments by one every cycle from 0 after reset and wraps at 2^CNT_W.
  - `start_stamp` holds the counter value of the accepted start cycle, from the next cycle on.
  - `rpt_count` equals the counter value in every stop cycle, so consecutive reports differ by exactly one.
- R3: Let S be the accepted start cycle and M the mask value. The first stop (`stop_en` and `rpt_valid` high) is in cycle S+1+M. M = 0 uses the very next edge, and M = 1 skips that edge.
- R4: Let N be the burst length. The block issues N stops in N consecutive cycles, with `rpt_index` counting 0 to N-1. A requested length of 0 is treated as 1, and a requested length above MAX_STOPS (5) is treated as 5.
- R5: `cfg_mask` and `cfg_nstops` are sampled only in the cycle a start is accepted. Changing them during a measurement has no effect on it.
- R6: `done` rises in the cycle after the last stop. It stays high until the cycle after the next accepted start.
- R7: A start event while `busy` is high is ignored and does not restart the sequence. `overrun_cnt` increases by one in the next cycle and saturates at its maximum value.
- R8: `busy` is high from cycle S+1 through the cycle of the last stop, and is low otherwise. `stop_en` is never high while `busy` is low.
- R9: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (10 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_async | input | 1 | Asynchronous once-per-second pulse |
| cfg_mask | input | MASK_W | Number of reference edges to blank after start |
| cfg_nstops | input | clog2(MAX_STOPS+1) | Requested number of stops in the burst |
| start_pulse | output | 1 | One-cycle synchronized start event |
| start_stamp | output | CNT_W | Coarse count captured at the accepted start |
| stop_en | output | 1 | Gate that passes one reference edge to the interpolator |
| rpt_valid | output | 1 | Stop report valid (no back-pressure) |
| rpt_count | output | CNT_W | Coarse count of the current stop edge |
| rpt_index | output | clog2(MAX_STOPS) | Index of the stop within the burst |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Last stop of the measurement has been issued |
| overrun_cnt | output | OVR_W | Saturating count of ignored start events |

## Verification
Each result has a fixed delay after its stimulus:

- The start event is due SYNC_STAGES cycles after the first edge that samples the pulse high.
- The start timestamp and any overrun count are due one cycle after the start event.
- The first stop is due 1+M cycles after the start event, and the rest of the burst follows on the next N-1 cycles.
- `done` is due one cycle after the last stop.

The bench models these delays from the cycle numbers of events, not from any state machine. It compares every output half a cycle after each edge. Directed checks then confirm the mask offset, the burst length, the clamping of the burst length and the behaviour on overrun.

// File: rtl/pps_gate_pkg.sv
package pps_gate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MASK = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_async,
  output logic start_pulse
);
  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0] chain;
  logic             last_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain    <= '0;
      last_lvl <= 1'b0;
    end else begin
      chain    <= {chain[DEPTH-2:0], pps_async};
      last_lvl <= chain[DEPTH-1];
    end
  end

  // rising edge of the resynchronized level
  assign start_pulse = chain[DEPTH-1] & ~last_lvl;
endmodule

// File: rtl/coarse_timebase.sv
module coarse_timebase #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] stamp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      stamp <= '0;
    end else begin
      count <= count + 1'b1;
      if (capture) stamp <= count;
    end
  end
endmodule

// File: rtl/stop_sequencer.sv
module stop_sequencer
  import pps_gate_pkg::*;
#(
  parameter int MASK_W    = 8,
  parameter int MAX_STOPS = 5,
  parameter int OVR_W     = 8,
  localparam int NS_W     = $clog2(MAX_STOPS + 1),
  localparam int IDX_W    = (MAX_STOPS > 1) ? $clog2(MAX_STOPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pulse,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic [NS_W-1:0]   cfg_nstops,
  output logic              accept,
  output logic              stop_en,
  output logic [IDX_W-1:0]  idx,
  output logic              busy,
  output logic              done,
  output logic [OVR_W-1:0]  overrun_cnt
);
  seq_state_t        st;
  logic [MASK_W-1:0] left;
  logic [IDX_W-1:0]  last_idx;
  logic [NS_W-1:0]   n_eff;
  logic              clash;

  always_comb begin
    if (cfg_nstops == '0)                        n_eff = NS_W'(1);
    else if (cfg_nstops > NS_W'(MAX_STOPS))      n_eff = NS_W'(MAX_STOPS);
    else                                         n_eff = cfg_nstops;
  end

  assign accept  = start_pulse && (st == ST_IDLE);
  assign clash   = start_pulse && (st != ST_IDLE);
  assign stop_en = (st == ST_RUN);
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      left        <= '0;
      idx         <= '0;
      last_idx    <= '0;
      done        <= 1'b0;
      overrun_cnt <= '0;
    end else begin
      if (clash && (overrun_cnt != '1)) overrun_cnt <= overrun_cnt + 1'b1;
      case (st)
        ST_IDLE: begin
          if (start_pulse) begin
            done     <= 1'b0;
            idx      <= '0;
            last_idx <= IDX_W'(n_eff - 1'b1);
            left     <= cfg_mask;
            st       <= (cfg_mask == '0) ? ST_RUN : ST_MASK;
          end
        end
        ST_MASK: begin
          left <= left - 1'b1;
          if (left == MASK_W'(1)) st <= ST_RUN;
        end
        ST_RUN: begin
          if (idx == last_idx) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pps_stop_gate.sv
module pps_stop_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 32,
  parameter int MASK_W      = 8,
  parameter int MAX_STOPS   = 5,
  parameter int OVR_W       = 8
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          pps_async,
  input  logic [MASK_W-1:0]                             cfg_mask,
  input  logic [$clog2(MAX_STOPS+1)-1:0]                cfg_nstops,
  output logic                                          start_pulse,
  output logic [CNT_W-1:0]                              start_stamp,
  output logic                                          stop_en,
  output logic                                          rpt_valid,
  output logic [CNT_W-1:0]                              rpt_count,
  output logic [((MAX_STOPS>1)?$clog2(MAX_STOPS):1)-1:0] rpt_index,
  output logic                                          busy,
  output logic                                          done,
  output logic [OVR_W-1:0]                              overrun_cnt
);
  logic accept;

  pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .pps_async   (pps_async),
    .start_pulse (start_pulse)
  );

  coarse_timebase #(.CNT_W(CNT_W)) u_time (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (accept),
    .count   (rpt_count),
    .stamp   (start_stamp)
  );

  stop_sequencer #(
    .MASK_W    (MASK_W),
    .MAX_STOPS (MAX_STOPS),
    .OVR_W     (OVR_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .cfg_mask    (cfg_mask),
    .cfg_nstops  (cfg_nstops),
    .accept      (accept),
    .stop_en     (stop_en),
    .idx         (rpt_index),
    .busy        (busy),
    .done        (done),
    .overrun_cnt (overrun_cnt)
  );

  assign rpt_valid = stop_en;
endmodule

// File: rtl/pps_stop_gate_chk.sv
module pps_stop_gate_chk #(
  parameter int CNT_W     = 32,
  parameter int MAX_STOPS = 5,
  parameter int OVR_W     = 8,
  localparam int IDX_W    = (MAX_STOPS > 1) ? $clog2(MAX_STOPS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_pulse,
  input logic [CNT_W-1:0] start_stamp,
  input logic             stop_en,
  input logic             rpt_valid,
  input logic [CNT_W-1:0] rpt_count,
  input logic [IDX_W-1:0] rpt_index,
  input logic             busy,
  input logic             done,
  input logic [OVR_W-1:0] overrun_cnt
);
  p_start_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  p_stamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !busy) |=> (start_stamp == $past(rpt_count)));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_en && $past(stop_en)) |-> (rpt_count == $past(rpt_count) + 1'b1));

  p_index_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_en && $past(stop_en)) |-> (rpt_index == $past(rpt_index) + 1'b1));

  p_index_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_en |-> (rpt_index < IDX_W'(MAX_STOPS)));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && busy) |=>
      ((overrun_cnt == $past(overrun_cnt) + 1'b1) || (&$past(overrun_cnt))));

  p_stop_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_en || rpt_valid) |-> busy);
endmodule

bind pps_stop_gate pps_stop_gate_chk #(
  .CNT_W     (CNT_W),
  .MAX_STOPS (MAX_STOPS),
  .OVR_W     (OVR_W)
) u_chk (.*);

// File: tb/pps_stop_gate_bench.sv
module pps_stop_gate_bench;
  localparam int SYNC = 2;
  localparam int CNT_W = 32;
  localparam int MAXS = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pps = 1'b0;
  logic [7:0]  cfg_mask = 8'd0;
  logic [2:0]  cfg_n = 3'd1;
  logic        start_pulse, stop_en, rpt_valid, busy, done;
  logic [31:0] start_stamp, rpt_count;
  logic [2:0]  rpt_index;
  logic [7:0]  overrun_cnt;

  pps_stop_gate u_pps_stop_gate (
    .clk(clk), .rst_n(rst_n), .pps_async(pps), .cfg_mask(cfg_mask),
    .cfg_nstops(cfg_n), .start_pulse(start_pulse), .start_stamp(start_stamp),
    .stop_en(stop_en), .rpt_valid(rpt_valid), .rpt_count(rpt_count),
    .rpt_index(rpt_index), .busy(busy), .done(done), .overrun_cnt(overrun_cnt)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int clampn(int v);
    if (v == 0) return 1;
    if (v > MAXS) return MAXS;
    return v;
  endfunction

  // behavioural reference: events by cycle number
  int cyc;
  int hist[SYNC+1];
  bit started;
  int c0, m_m, m_n;
  int unsigned m_cnt, m_stamp;
  int m_ovr;
  bit model_on;
  bit e_start, e_stop, e_busy, e_done;
  int e_idx, e_ovr;
  int unsigned e_count, e_stamp;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; started = 0; m_cnt = 0; m_stamp = 0; m_ovr = 0; model_on = 0;
      c0 = 0; m_m = 0; m_n = 0;
      for (int i = 0; i <= SYNC; i++) hist[i] = 0;
    end else begin
      cyc++;
      m_cnt++;
      for (int i = SYNC; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = int'(pps);
      e_start = (hist[SYNC-1] == 1) && (hist[SYNC] == 0);
      e_busy  = started && (cyc >= c0 + 1) && (cyc <= c0 + m_m + m_n);
      e_stop  = started && (cyc >= c0 + 1 + m_m) && (cyc <= c0 + m_m + m_n);
      e_done  = started && (cyc > c0 + m_m + m_n);
      e_idx   = cyc - (c0 + 1 + m_m);
      e_count = m_cnt;
      e_stamp = m_stamp;
      e_ovr   = m_ovr;
      if (e_start) begin
        if (e_busy) begin
          if (m_ovr < 255) m_ovr++;
        end else begin
          started = 1; c0 = cyc; m_m = int'(cfg_mask); m_n = clampn(int'(cfg_n));
          m_stamp = m_cnt;
        end
      end
      model_on = 1;
    end
  end

  // observation bookkeeping for directed checks
  int stops_seen;
  int t_start, t_first;

  always @(negedge clk) begin
    if (rst_n && model_on && !finished) begin
      chk("R1", "start_pulse", 64'(start_pulse), 64'(e_start));
      chk("R3", "stop_en", 64'(stop_en), 64'(e_stop));
      chk("R3", "rpt_valid", 64'(rpt_valid), 64'(e_stop));
      chk("R8", "busy", 64'(busy), 64'(e_busy));
      chk("R6", "done", 64'(done), 64'(e_done));
      chk("R2", "start_stamp", 64'(start_stamp), 64'(e_stamp));
      chk("R7", "overrun_cnt", 64'(overrun_cnt), 64'(e_ovr));
      if (e_stop) begin
        chk("R4", "rpt_index", 64'(rpt_index), 64'(e_idx));
        chk("R2", "rpt_count", 64'(rpt_count), 64'(e_count));
      end
      if (start_pulse && !busy) t_start = cyc;
      if (stop_en) begin
        if (t_first < 0) t_first = cyc;
        stops_seen++;
      end
    end
  end

  task automatic pulse(int width);
    @(negedge clk) pps = 1'b1;
    repeat (width) @(negedge clk);
    pps = 1'b0;
  endtask

  task automatic arm(int m, int n);
    @(negedge clk);
    cfg_mask = 8'(m);
    cfg_n = 3'(n);
    stops_seen = 0;
    t_first = -1;
    t_start = -1;
  endtask

  task automatic settle(int m);
    repeat (m + 20) @(negedge clk);
  endtask

  task automatic meas(int m, int n, string tag);
    arm(m, n);
    pulse(1);
    settle(m);
    chk(tag, "stop count", 64'(stops_seen), 64'(clampn(n)));
    chk("R3", "first stop offset", 64'(t_first - t_start), 64'(1 + m));
  endtask

  initial begin
    int ovr_before;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "start_pulse", 64'(start_pulse), 64'd0);
    chk("R9", "stop_en", 64'(stop_en), 64'd0);
    chk("R9", "rpt_valid", 64'(rpt_valid), 64'd0);
    chk("R9", "busy", 64'(busy), 64'd0);
    chk("R9", "done", 64'(done), 64'd0);
    chk("R9", "start_stamp", 64'(start_stamp), 64'd0);
    chk("R9", "overrun_cnt", 64'(overrun_cnt), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    meas(0, 1, "R4");       // next edge, single stop
    meas(1, 5, "R4");       // skip first edge, full burst
    meas(3, 3, "R4");
    meas(2, 0, "R4");       // length 0 treated as 1
    meas(0, 7, "R4");       // length 7 treated as 5
    meas(12, 4, "R4");

    // R1: wide input pulse gives one start
    arm(0, 1);
    pulse(30);
    settle(0);
    chk("R1", "stops from wide pulse", 64'(stops_seen), 64'd1);

    // R5: configuration changed mid-measurement has no effect
    arm(6, 2);
    pulse(1);
    repeat (4) @(negedge clk);
    cfg_mask = 8'd0;
    cfg_n = 3'd5;
    settle(6);
    chk("R5", "stop count after cfg change", 64'(stops_seen), 64'd2);
    chk("R5", "first stop offset after cfg change", 64'(t_first - t_start), 64'd7);

    // R7: second pulse during a measurement
    ovr_before = int'(overrun_cnt);
    arm(20, 5);
    pulse(1);
    repeat (8) @(negedge clk);
    pulse(2);
    settle(20);
    chk("R7", "overrun increment", 64'(overrun_cnt), 64'(ovr_before + 1));
    chk("R7", "no restart stop count", 64'(stops_seen), 64'd5);

    // tight pulse trains: model checks start/done/overrun timing
    arm(2, 3);
    for (int g = 0; g < 12; g++) begin
      pulse(1);
      repeat (g + 1) @(negedge clk);
    end
    settle(2);
    chk("R6", "done after train", 64'(done), 64'd1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule